// File: doc/BRIEF.md
# Asynchronous Bus Slave Handshake Controller

This block is the slave-side protocol engine for a peripheral that sits on an asynchronous processor bus where address and data share the same lines. At the start of every bus cycle, marked by the rising sync strobe, it captures whether the upstream address comparator reported a hit, and it captures the three low address bits. For a hit, it then holds one of four register select lines for the rest of the cycle. These lines address the receive control/status, receive data, transmit control/status and transmit data registers.

During the data phase the controller does three things. It raises a read-direction output so the transceivers drive module data onto the bus, or it raises low and high byte write strobes. It then answers the master with a reply once a programmable settle time has passed, and drops that reply when the master removes its data strobe. Separately, an interrupt vector request gets an immediate reply that does not depend on sync or on the address match. All bus inputs are active high at the block's pins. They are asynchronous to the system clock and pass through multi-flop synchronizers first.

Top module: `bus_slave_ctrl`

## Requirements
- R1: On the clock where the synchronized sync strobe is first seen high with the match input true, `reg_sel` becomes one-hot from address bits 2:1. 00 gives bit 0 (receive control/status), 01 gives bit 1 (receive data), 10 gives bit 2 (transmit control/status) and 11 gives bit 3 (transmit data). The selection then holds until sync falls, even if the address lines change.
- R2: In a cycle whose match was false at the sync edge, `reg_sel`, `rd_dir`, `wr_lo`, `wr_hi` stay 0, and `reply` stays 0 unless a vector request is active.
- R3: Once the synchronized sync strobe is low, `reg_sel`, `rd_dir`, `wr_lo` and `wr_hi` are all 0 from the next clock on.
- R4: In a matched cycle, `rd_dir` is 1 while the data-in strobe is high, appearing SYNC_STAGES+1 clock edges after it rises and clearing the same number of edges after it falls.
- R5: In a matched cycle with exactly one data strobe high, `reply` rises on the SETTLE_CYC+SYNC_STAGES-th rising clock edge after the strobe rises at the pin. It falls SYNC_STAGES+1 edges after that strobe falls.
- R6: In a matched cycle, the byte strobes follow the byte qualifier sampled during data-out. Qualifier 0 raises both `wr_lo` and `wr_hi`. Qualifier 1 with captured address bit 0 equal to 0 raises only `wr_lo`, and with bit 0 equal to 1 raises only `wr_hi`. Neither strobe is raised outside data-out.
- R7: `vec_req` raises `reply` SYNC_STAGES+1 edges after it rises, independent of sync and match, and removes it the same number of edges after it falls.
- R8: With data-in and data-out high together, no reply, no direction and no byte strobe is produced.
- R9: While reset is held and immediately after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sync | input | 1 | Bus cycle sync strobe (asynchronous) |
| bus_din | input | 1 | Data-in (read) strobe |
| bus_dout | input | 1 | Data-out (write) strobe |
| bus_byte | input | 1 | Write/byte qualifier |
| bus_match | input | 1 | Address comparator hit |
| bus_addr | input | 3 | Low address bits 2:0 |
| vec_req | input | 1 | Interrupt vector reply request |
| reg_sel | output | 4 | One-hot register select |
| rd_dir | output | 1 | Transceiver read direction |
| wr_lo | output | 1 | Low byte write strobe |
| wr_hi | output | 1 | High byte write strobe |
| reply | output | 1 | Bus reply |

## Verification
The bench sweeps all eight address values, with and without a match, through read, word-write and byte-write cycles. After the sync edge it scrambles the address lines: a design that decodes live address would then switch registers mid-cycle, or would let the high/low choice follow the wrong bit. It counts the exact clock edge on which the reply rises and falls, so an off-by-one settle counter or a reply held after the strobe drops is caught. It also drives both data strobes at once and a vector request with no sync: a design that replies to the conflict, or that gates the vector reply with match, fails there.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int NUM_SEL = 4;

    function automatic logic [NUM_SEL-1:0] sel_decode(input logic [1:0] idx);
        logic [NUM_SEL-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= '0;
                else        chain_q[i] <= chain_d[i];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bsc_settle.sv
module bsc_settle #(
    parameter int SETTLE_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          done_d, done_q;

    always_comb begin
        if (!run)                cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
        done_d = run && (cnt_d == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/bus_slave_ctrl.sv
module bus_slave_ctrl #(
    parameter int SETTLE_CYC  = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sync,
    input  logic       bus_din,
    input  logic       bus_dout,
    input  logic       bus_byte,
    input  logic       bus_match,
    input  logic [2:0] bus_addr,
    input  logic       vec_req,
    output logic [3:0] reg_sel,
    output logic       rd_dir,
    output logic       wr_lo,
    output logic       wr_hi,
    output logic       reply
);
    import bsc_pkg::*;

    localparam int IN_W = 9;

    typedef struct packed {
        logic               sync_prev;
        logic               active;
        logic [2:0]         addr;
        logic [NUM_SEL-1:0] sel;
        logic               rd;
        logic               lo;
        logic               hi;
        logic               vec;
    } ctl_t;

    logic [IN_W-1:0] raw_in, sync_in;
    logic [2:0]      s_addr;
    logic            s_sync, s_din, s_dout, s_byte, s_match, s_vec;
    logic            strobe_ok;
    logic            settle_done;
    ctl_t            ctl_d, ctl_q;

    assign raw_in = {vec_req, bus_match, bus_byte, bus_dout, bus_din, bus_sync, bus_addr};

    bsc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign s_addr  = sync_in[2:0];
    assign s_sync  = sync_in[3];
    assign s_din   = sync_in[4];
    assign s_dout  = sync_in[5];
    assign s_byte  = sync_in[6];
    assign s_match = sync_in[7];
    assign s_vec   = sync_in[8];

    // exactly one data strobe inside a matched cycle
    assign strobe_ok = s_sync && ctl_q.active && (s_din != s_dout);

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.sync_prev = s_sync;
        ctl_d.vec       = s_vec;
        if (!s_sync) begin
            ctl_d.active = 1'b0;
            ctl_d.sel    = '0;
        end else if (!ctl_q.sync_prev) begin
            ctl_d.active = s_match;
            ctl_d.addr   = s_addr;
            ctl_d.sel    = s_match ? sel_decode(s_addr[2:1]) : '0;
        end
        ctl_d.rd = strobe_ok && s_din;
        ctl_d.lo = strobe_ok && s_dout && (!s_byte || !ctl_q.addr[0]);
        ctl_d.hi = strobe_ok && s_dout && (!s_byte ||  ctl_q.addr[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bsc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (strobe_ok),
        .done  (settle_done)
    );

    assign reg_sel = ctl_q.sel;
    assign rd_dir  = ctl_q.rd;
    assign wr_lo   = ctl_q.lo;
    assign wr_hi   = ctl_q.hi;
    assign reply   = settle_done || ctl_q.vec;
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_sync,
    input logic       s_din,
    input logic       s_dout,
    input logic       s_vec,
    input logic [3:0] reg_sel,
    input logic       rd_dir,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic       reply
);
    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel));

    // R3
    sync_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_sync |=> (reg_sel == 4'b0) && !rd_dir && !wr_lo && !wr_hi);

    // R4
    rd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dir |-> ($onehot(reg_sel) && !wr_lo && !wr_hi));

    // R6
    wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |-> $onehot(reg_sel));

    // R7
    vec_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_vec |=> reply);

    // R8
    conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_din && s_dout && !s_vec) |=> !reply && !rd_dir && !wr_lo && !wr_hi);
endmodule

bind bus_slave_ctrl bsc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_sync  (s_sync),
    .s_din   (s_din),
    .s_dout  (s_dout),
    .s_vec   (s_vec),
    .reg_sel (reg_sel),
    .rd_dir  (rd_dir),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .reply   (reply)
);

// File: tb/tb_bus_slave_ctrl.sv
`timescale 1ns/1ps
module tb_bus_slave_ctrl;
    localparam int SETTLE = 15;
    localparam int STG    = 2;
    localparam int LAT    = STG + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sync = 0, bus_din = 0, bus_dout = 0, bus_byte = 0, bus_match = 0, vec_req = 0;
    logic [2:0] bus_addr = '0;
    logic [3:0] reg_sel;
    logic       rd_dir, wr_lo, wr_hi, reply;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bus_slave_ctrl #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sync(bus_sync), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_byte(bus_byte), .bus_match(bus_match),
        .bus_addr(bus_addr), .vec_req(vec_req), .reg_sel(reg_sel),
        .rd_dir(rd_dir), .wr_lo(wr_lo), .wr_hi(wr_hi), .reply(reply)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance n rising edges, then sample 1 ns later
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // count edges until reply reaches level lvl (limit 60)
    task automatic wait_reply(input logic lvl, output int cnt);
        cnt = 0;
        while (reply !== lvl && cnt < 60) begin
            @(posedge clk); #1; cnt++;
        end
    endtask

    // kind: 0 read, 1 word write, 2 byte write
    task automatic bus_cycle(input logic [2:0] a, input logic m, input int kind);
        logic [3:0] exp_sel;
        logic       exp_lo, exp_hi;
        int         n;
        exp_sel = m ? (4'b1 << a[2:1]) : 4'b0;
        @(negedge clk);
        bus_addr = a; bus_match = m; bus_byte = (kind != 0);
        edges(2);
        @(negedge clk); bus_sync = 1;
        edges(LAT);
        check(reg_sel == exp_sel, m ? "R1 select decode" : "R2 no select", reg_sel, exp_sel);
        @(negedge clk);
        bus_addr = ~a; bus_match = 0;           // scramble: captured values must hold
        if (kind == 1) bus_byte = 0;
        edges(2);
        check(reg_sel == exp_sel, "R1 select held", reg_sel, exp_sel);
        @(negedge clk);
        if (kind == 0) bus_din = 1; else bus_dout = 1;
        wait_reply(1'b1, n);
        if (m) check(n == SETTLE + STG, "R5 reply rise edge", n, SETTLE + STG);
        else   check(n == 60, "R2 no reply", n, 60);
        if (kind == 0) begin
            check(rd_dir == m, m ? "R4 read direction" : "R2 no direction", rd_dir, m);
            check(!wr_lo && !wr_hi, "R6 no strobe on read", {wr_hi, wr_lo}, 0);
        end else begin
            exp_lo = m && (kind == 1 || !a[0]);
            exp_hi = m && (kind == 1 ||  a[0]);
            check({wr_hi, wr_lo} == {exp_hi, exp_lo}, m ? "R6 byte lanes" : "R2 no lanes",
                  {wr_hi, wr_lo}, {exp_hi, exp_lo});
            check(!rd_dir, "R4 no direction on write", rd_dir, 0);
        end
        @(negedge clk); bus_din = 0; bus_dout = 0;
        if (m) begin
            wait_reply(1'b0, n);
            check(n == LAT, "R5 reply release edge", n, LAT);
        end else edges(LAT);
        check(!rd_dir && !wr_lo && !wr_hi, "R4 strobes off after data", {rd_dir, wr_hi, wr_lo}, 0);
        @(negedge clk); bus_sync = 0; bus_byte = 0;
        edges(LAT);
        check(reg_sel == 0, "R3 select cleared", reg_sel, 0);
    endtask

    initial begin
        int n;
        edges(3);
        check(reg_sel == 0 && !rd_dir && !wr_lo && !wr_hi && !reply, "R9 reset state",
              {reg_sel, rd_dir, wr_lo, wr_hi, reply}, 0);
        @(negedge clk); rst_n = 1;
        edges(2);
        check({reg_sel, rd_dir, wr_lo, wr_hi, reply} == 0, "R9 after reset",
              {reg_sel, rd_dir, wr_lo, wr_hi, reply}, 0);

        for (int k = 0; k < 3; k++)
            for (int m = 1; m >= 0; m--)
                for (int a = 0; a < 8; a++)
                    bus_cycle(3'(a), 1'(m), k);

        // R7 vector with no sync and no match
        @(negedge clk); vec_req = 1;
        wait_reply(1'b1, n);
        check(n == LAT, "R7 vector reply edge", n, LAT);
        check(reg_sel == 0, "R7 vector no select", reg_sel, 0);
        @(negedge clk); vec_req = 0;
        wait_reply(1'b0, n);
        check(n == LAT, "R7 vector release edge", n, LAT);

        // R8 both data strobes in a matched cycle
        @(negedge clk); bus_addr = 3'd2; bus_match = 1;
        edges(2);
        @(negedge clk); bus_sync = 1;
        edges(LAT);
        @(negedge clk); bus_din = 1; bus_dout = 1;
        edges(SETTLE + STG + 4);
        check(!reply, "R8 no reply on conflict", reply, 0);
        check(!rd_dir && !wr_lo && !wr_hi, "R8 no strobes on conflict", {rd_dir, wr_hi, wr_lo}, 0);
        // R3 sync dropped mid data phase
        @(negedge clk); bus_din = 0;
        edges(SETTLE + STG + 2);
        check(wr_lo && wr_hi, "R6 word lanes after conflict", {wr_hi, wr_lo}, 3);
        @(negedge clk); bus_sync = 0;
        edges(LAT);
        check(reg_sel == 0 && !wr_lo && !wr_hi && !reply, "R3 sync drop clears",
              {reg_sel, wr_hi, wr_lo, reply}, 0);
        @(negedge clk); bus_dout = 0; bus_match = 0;
        edges(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule